// File: doc/BRIEF.md
# Direct-Mapped Instruction Translation Buffer

This block caches recent effective-to-real page translations for an instruction fetch unit. A fetch stage presents a 64-bit effective address with a request strobe. One clock later the block returns a result strobe, a hit or miss flag and, on a hit, a 56-bit real address. The 12 low address bits, the offset inside a 4 KiB page, pass through unchanged.

The buffer is direct mapped with 64 slots. The slot for an address comes from XOR-folding three 6-bit fields that sit directly above the page offset. Folding these fields spreads neighbouring code regions over different slots.

Each slot holds a valid flag, the upper 46 bits of the effective address as a tag, and a 64-bit page table entry. The memory-management side fills one slot per clock through a load port. A single-cycle flush input drops every translation at once.

Top module: `itlb_direct`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid`, `res_hit` and `res_miss` are low. Every slot is empty after reset, so the first lookup of any address reports a miss.
- R2: The slot index of an address `a` is `a[17:12] ^ a[23:18] ^ a[29:24]`. It is the same for loads and lookups.
- R3: A lookup with `look_req` high in cycle t produces, in cycle t+1, `res_valid` high and exactly one of `res_hit` or `res_miss` high. `res_hit` means the indexed slot is valid and its stored tag equals `a[63:18]` of the looked-up address. Two addresses with the same index but different tags do not hit each other's slot.
- R4: On a hit, `res_addr` equals `{pte[55:12], a[11:0]}`, where `pte` is the stored entry and `a` is the looked-up address. When `res_hit` is low, `res_addr` is zero.
- R5: With `fill_en` high in cycle t, the slot at the index of `fill_ea` receives that tag and `fill_pte` and becomes valid at the clock edge ending cycle t. A lookup requested in cycle t+1 sees the new contents.
- R6: With `flush_all` high in cycle t, every slot is invalid after the clock edge ending cycle t. If `fill_en` is high in the same cycle, the flush wins and the filled slot is also invalid.
- R7: A lookup requested in the same cycle as a fill or a flush sees the slot contents from before that clock edge.
- R8: When `look_req` is low in cycle t, `res_valid`, `res_hit` and `res_miss` are low in cycle t+1.
- R9: A fill replaces whatever a slot held, so a later fill of a different address with the same index makes the earlier address miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_req | input | 1 | Lookup request strobe |
| look_ea | input | 64 | Effective address to translate |
| res_valid | output | 1 | A lookup result is presented this cycle |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | No valid matching slot |
| res_addr | output | 56 | Real address on a hit, zero otherwise |
| fill_en | input | 1 | Write one slot |
| fill_ea | input | 64 | Effective address whose translation is filled |
| fill_pte | input | 64 | Page table entry stored with it |
| flush_all | input | 1 | Invalidate every slot |

## Verification
The hardest case to reach from the ports is telling the folded index apart from a plain low-bit index. The bench uses three crafted addresses. Two of them share folded slot 7 but differ in their lowest field. The third has the same lowest field as the first but a different folded slot (1). Filling the third must leave the first hitting, and filling the second must evict it. Same-cycle collisions are driven in single cycles: a fill or flush together with a lookup, and a flush together with a fill.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int unsigned VA_BITS   = 64;
  localparam int unsigned RA_BITS   = 56;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned SLOTS     = 64;
  localparam int unsigned PTE_BITS  = 64;
  localparam int unsigned NUM_FOLDS = 3;
endpackage

// File: rtl/itlb_fold.sv
module itlb_fold #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned SHIFT = 12,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned FOLDS = 3
) (
  input  logic [VA_W-1:0]  ea,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] acc [FOLDS+1];

  assign acc[0] = '0;
  for (genvar f = 0; f < FOLDS; f++) begin : g_fold
    assign acc[f+1] = acc[f] ^ ea[SHIFT + f*IDX_W +: IDX_W];
  end
  assign idx = acc[FOLDS];

  logic unused_ea_bits;
  assign unused_ea_bits = ^{ea[VA_W-1:SHIFT+FOLDS*IDX_W], ea[SHIFT-1:0]};
endmodule

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ROW_W = 110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_row,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ROW_W-1:0] rd_row,
  output logic             rd_vld
);
  logic [ROW_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0] vld;

  // Tag and entry array: plain synchronous RAM, read-before-write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_row;
    if (rd_en) rd_row <= mem[rd_idx];
  end

  // Valid flags kept in flops so a flush clears them in one edge
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= rd_en & vld[rd_idx];
  end
endmodule

// File: rtl/itlb_direct.sv
module itlb_direct
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W   = VA_BITS,
  parameter int unsigned RA_W   = RA_BITS,
  parameter int unsigned SHIFT  = PG_SHIFT,
  parameter int unsigned N_SLOT = SLOTS,
  parameter int unsigned PTE_W  = PTE_BITS,
  parameter int unsigned FOLDS  = NUM_FOLDS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            look_req,
  input  logic [63:0]     look_ea,
  output logic            res_valid,
  output logic            res_hit,
  output logic            res_miss,
  output logic [55:0]     res_addr,
  input  logic            fill_en,
  input  logic [63:0]     fill_ea,
  input  logic [63:0]     fill_pte,
  input  logic            flush_all
);
  localparam int unsigned IDX_W = $clog2(N_SLOT);
  localparam int unsigned TAG_W = VA_W - SHIFT - IDX_W;
  localparam int unsigned ROW_W = TAG_W + PTE_W;
  localparam int unsigned PPN_W = RA_W - SHIFT;

  logic [IDX_W-1:0] look_idx, fill_idx;
  logic [ROW_W-1:0] rd_row;
  logic             rd_vld;
  logic             req_q;
  logic [TAG_W-1:0] tag_q;
  logic [SHIFT-1:0] off_q;

  itlb_fold #(.VA_W(VA_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .FOLDS(FOLDS))
    u_fold_look (.ea(look_ea), .idx(look_idx));

  itlb_fold #(.VA_W(VA_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .FOLDS(FOLDS))
    u_fold_fill (.ea(fill_ea), .idx(fill_idx));

  itlb_store #(.SLOTS(N_SLOT), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fill_en),
    .wr_idx  (fill_idx),
    .wr_row  ({fill_ea[VA_W-1 -: TAG_W], fill_pte}),
    .clr_all (flush_all),
    .rd_en   (look_req),
    .rd_idx  (look_idx),
    .rd_row  (rd_row),
    .rd_vld  (rd_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      tag_q <= '0;
      off_q <= '0;
    end else begin
      req_q <= look_req;
      if (look_req) begin
        tag_q <= look_ea[VA_W-1 -: TAG_W];
        off_q <= look_ea[SHIFT-1:0];
      end
    end
  end

  logic [TAG_W-1:0] st_tag;
  logic [PTE_W-1:0] st_pte;
  logic             hit;

  assign st_tag = rd_row[ROW_W-1 -: TAG_W];
  assign st_pte = rd_row[PTE_W-1:0];
  assign hit    = req_q & rd_vld & (st_tag == tag_q);

  assign res_valid = req_q;
  assign res_hit   = hit;
  assign res_miss  = req_q & ~hit;
  assign res_addr  = hit ? {st_pte[RA_W-1:SHIFT], off_q} : '0;

  logic unused_bits;
  assign unused_bits = ^{fill_ea[SHIFT+IDX_W-1:0], st_pte[PTE_W-1:RA_W]};
endmodule

// File: rtl/itlb_direct_chk.sv
module itlb_direct_chk (
  input logic        clk,
  input logic        rst,
  input logic        look_req,
  input logic [63:0] look_ea,
  input logic        res_valid,
  input logic        res_hit,
  input logic        res_miss,
  input logic [55:0] res_addr,
  input logic        flush_all
);
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit ^ res_miss));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    look_req |=> res_valid);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !look_req |=> (!res_valid && !res_hit && !res_miss));

  p_offset_r4: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_addr[11:0] == $past(look_ea[11:0])));

  p_zero_on_miss_r4: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_addr == 56'd0));

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(flush_all, 2)) |-> !res_hit);
endmodule

bind itlb_direct itlb_direct_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .look_req  (look_req),
  .look_ea   (look_ea),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_miss  (res_miss),
  .res_addr  (res_addr),
  .flush_all (flush_all)
);

// File: tb/itlb_direct_test.sv
`timescale 1ns/1ps
module itlb_direct_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        look_req = 1'b0;
  logic [63:0] look_ea = '0;
  logic        res_valid, res_hit, res_miss;
  logic [55:0] res_addr;
  logic        fill_en = 1'b0;
  logic [63:0] fill_ea = '0;
  logic [63:0] fill_pte = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  itlb_direct uut (
    .clk(clk), .rst(rst), .look_req(look_req), .look_ea(look_ea),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_addr(res_addr), .fill_en(fill_en), .fill_ea(fill_ea),
    .fill_pte(fill_pte), .flush_all(flush_all)
  );

  function automatic logic [63:0] mk_ea(input logic [33:0] hi, input logic [5:0] f2,
                                        input logic [5:0] f1, input logic [5:0] f0,
                                        input logic [11:0] off);
    return {hi, f2, f1, f0, off};
  endfunction

  function automatic logic [55:0] exp_ra(input logic [63:0] pte, input logic [63:0] ea);
    return {pte[55:12], ea[11:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [63:0] ea, input logic [63:0] pte);
    @(negedge clk);
    fill_en = 1'b1; fill_ea = ea; fill_pte = pte;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Issues one lookup and checks hit/miss and address one cycle later
  task automatic look(input string req, input logic [63:0] ea,
                      input logic exp_hit, input logic [55:0] exp_addr);
    @(negedge clk);
    look_req = 1'b1; look_ea = ea;
    @(negedge clk);
    look_req = 1'b0;
    chk(req, {61'd0, res_valid, res_hit, res_miss}, {61'd0, 1'b1, exp_hit, ~exp_hit});
    chk(req, {8'd0, res_addr}, {8'd0, exp_hit ? exp_addr : 56'd0});
  endtask

  localparam logic [63:0] PA = 64'h00AB_CDEF_1234_5000;
  localparam logic [63:0] PB = 64'h0011_2233_4455_6000;
  localparam logic [63:0] PC = 64'h0077_0000_9999_A000;

  task automatic t_reset;
    chk("R1", {61'd0, res_valid, res_hit, res_miss}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {61'd0, res_valid, res_hit, res_miss}, 64'd0);
    look("R1", mk_ea(34'h1, 6'd4, 6'd2, 6'd1, 12'h123), 1'b0, '0);
  endtask

  task automatic t_basic_and_hash;
    logic [63:0] a, b, c;
    a = mk_ea(34'h2_1234_5678, 6'd4, 6'd2, 6'd1, 12'h048); // slot 7
    b = mk_ea(34'h0_0000_0009, 6'd0, 6'd0, 6'd7, 12'h100); // slot 7
    c = mk_ea(34'h0_0000_0003, 6'd0, 6'd0, 6'd1, 12'h200); // slot 1
    fill(a, PA);
    look("R5", a, 1'b1, exp_ra(PA, a));
    look("R4", {a[63:12], 12'hFFC}, 1'b1, exp_ra(PA, {a[63:12], 12'hFFC}));
    // same low field, different folded slot: must not evict a
    fill(c, PC);
    look("R2", a, 1'b1, exp_ra(PA, a));
    look("R2", c, 1'b1, exp_ra(PC, c));
    // different low field, same folded slot: evicts a
    fill(b, PB);
    look("R9", a, 1'b0, '0);
    look("R9", b, 1'b1, exp_ra(PB, b));
    // same index, tag differs only in the top bit
    look("R3", {~b[63], b[62:0]}, 1'b0, '0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R8", {61'd0, res_valid, res_hit, res_miss}, 64'd0);
    chk("R8", {8'd0, res_addr}, 64'd0);
  endtask

  task automatic t_same_cycle_fill;
    logic [63:0] x;
    x = mk_ea(34'h3_0000_0001, 6'd9, 6'd5, 6'd3, 12'h010);
    @(negedge clk);
    fill_en = 1'b1; fill_ea = x; fill_pte = PC;
    look_req = 1'b1; look_ea = x;
    @(negedge clk);
    fill_en = 1'b0; look_req = 1'b0;
    chk("R7", {63'd0, res_miss}, 64'd1);
    look("R7", x, 1'b1, exp_ra(PC, x));
  endtask

  task automatic t_flush;
    logic [63:0] x, y;
    x = mk_ea(34'h0_0000_0AAA, 6'd1, 6'd1, 6'd1, 12'h004);
    y = mk_ea(34'h0_0000_0BBB, 6'd2, 6'd3, 6'd4, 12'h008);
    fill(x, PA);
    // flush with a lookup in the same cycle sees the old entry
    @(negedge clk);
    flush_all = 1'b1; look_req = 1'b1; look_ea = x;
    @(negedge clk);
    flush_all = 1'b0; look_req = 1'b0;
    chk("R7", {63'd0, res_hit}, 64'd1);
    look("R6", x, 1'b0, '0);
    fill(x, PA);
    // flush and fill together: flush wins
    @(negedge clk);
    flush_all = 1'b1; fill_en = 1'b1; fill_ea = y; fill_pte = PB;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    look("R6", x, 1'b0, '0);
    look("R6", y, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_basic_and_hash;
    t_idle;
    t_same_cycle_fill;
    t_flush;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule